// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a small on-chip synchronous static memory. It accepts one command on every rising clock edge and lets reads and writes alternate with no idle cycle between them. Write data reaches the shared data bus late: one cycle after its address in flow-through mode and two cycles after it in pipelined mode. Because of this, the bus slot a write uses is the slot a read in the same position would have used for its result. A host can therefore keep the bus busy on every cycle whatever the mix of commands.

A command is a load, which starts a new access at the given address, or an advance, which continues the current access at the next position of a four-beat burst. The burst can step in linear or interleaved order. Three enables must all be high for a load to be accepted. Writes carry per-byte enables over 9-bit bytes. The output-enable and sleep inputs act on the bus drivers at once, without waiting for a clock edge. The bidirectional bus is modelled as separate input, output and drive-enable ports.

Top module: `nbt_sram`

## Requirements
- R1: In flow-through mode (`pipe_mode`=0), a read loaded at edge k drives the word stored at its address on `dq_out` with `dq_oe`=1 during the cycle that follows edge k.
- R2: In pipelined mode (`pipe_mode`=1), the read result appears one cycle later than in R1, during the cycle that follows edge k+1.
- R3: The data of a write accepted at edge k is taken from `dq_in` at edge k+1 in flow-through mode and at edge k+2 in pipelined mode. `dq_in` is ignored at every other edge. The data slot of a write never drives the bus.
- R4: Read, write and read commands on consecutive edges to one address all complete with no idle cycle, and each read returns the newest value.
- R5: An advance (`adv`=1) with `interleave`=0 accesses base[1:0]+n modulo 4 on beat n, with the upper address bits held. It repeats the burst's read or write type and ignores `wr` and the enables.
- R6: With `interleave`=1, beat n accesses base[1:0] XOR n.
- R7: `byte_we[b]`=1 writes bits [9b+8:9b]. A byte whose enable is 0 keeps its stored value.
- R8: A load cycle (`adv`=0) without `ce0`, `ce1` and `ce2` all high is a deselect. It performs no access, drives nothing in its result slot and ends any burst. After reset nothing is driven.
- R9: `oe`=0 forces `dq_oe` low at once, with no clock edge.
- R10: `sleep`=1 forces `dq_oe` low at once, and a command sampled while `sleep` is high is ignored. A late-write data transfer still completes during sleep.
- R11: In pipelined mode, a read whose word is written at the same edge its result is captured returns the new bytes for the enabled lanes and the stored bytes for the rest.
- R12: An advance while no burst is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| pipe_mode | input | 1 | 1 = pipelined, 0 = flow-through; changed only under reset |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| ce0 | input | 1 | Enable, active high |
| ce1 | input | 1 | Enable, active high |
| ce2 | input | 1 | Enable, active high |
| adv | input | 1 | 1 = advance burst, 0 = load new address |
| wr | input | 1 | Load type: 1 write, 0 read |
| addr | input | ADDR_W | Word address for a load |
| byte_we | input | NUM_BYTES | Per-byte write enables of this command |
| dq_in | input | NUM_BYTES*BYTE_W | Bus value seen by the block |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Power-down request |
| dq_out | output | NUM_BYTES*BYTE_W | Value offered to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
A flow-through read result is due in the cycle after its command edge and a pipelined one a cycle later. Write data is due on the bus one or two cycles after the command edge, in that same result slot. The bench keeps a small ring of result slots indexed by cycle. It fills the slots when it issues a command and compares `dq_out` and `dq_oe` at the falling edge of the slot's cycle. It drives real write data only in the slot where the data is due and random values everywhere else. The asynchronous effects of `oe` and `sleep` are checked a nanosecond after the input changes, between clock edges.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   // low address bits of burst beat n, from the burst start
   function automatic logic [1:0] beat_low(input logic [1:0] start,
                                           input logic [1:0] n,
                                           input logic       ilv);
      return ilv ? (start ^ n) : (start + n);
   endfunction

endpackage

// File: rtl/nbt_burst_ctl.sv
module nbt_burst_ctl
   import nbt_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int NUM_BYTES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sleep,
   input  logic                 cmd_sel,
   input  logic                 adv,
   input  logic                 wr,
   input  logic                 interleave,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [NUM_BYTES-1:0] byte_we,
   output op_e                  s1_op,
   output logic [ADDR_W-1:0]    s1_addr,
   output logic [NUM_BYTES-1:0] s1_be
);

   logic              act, bwr;
   logic [ADDR_W-1:0] base;
   logic [1:0]        cnt, cnt_nx;
   logic              do_load, do_step, do_drop;

   always_comb begin
      do_load = !sleep && !adv && cmd_sel;
      do_step = !sleep && adv && act;
      do_drop = !sleep && !adv && !cmd_sel;
      cnt_nx  = cnt + 2'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act     <= 1'b0;
         bwr     <= 1'b0;
         base    <= '0;
         cnt     <= '0;
         s1_op   <= OP_NONE;
         s1_addr <= '0;
         s1_be   <= '0;
      end else begin
         s1_be <= byte_we;
         if (do_load) begin
            act     <= 1'b1;
            bwr     <= wr;
            base    <= addr;
            cnt     <= '0;
            s1_op   <= wr ? OP_WRITE : OP_READ;
            s1_addr <= addr;
         end else if (do_step) begin
            cnt     <= cnt_nx;
            s1_op   <= bwr ? OP_WRITE : OP_READ;
            s1_addr <= {base[ADDR_W-1:2], beat_low(base[1:0], cnt_nx, interleave)};
         end else begin
            s1_op <= OP_NONE;
            if (do_drop) act <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/nbt_mem_array.sv
module nbt_mem_array #(
   parameter int ADDR_W    = 4,
   parameter int NUM_BYTES = 2,
   parameter int BYTE_W    = 9
) (
   input  logic                        clk,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [NUM_BYTES-1:0]        wr_be,
   input  logic [NUM_BYTES*BYTE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0]           rd_addr,
   output logic [NUM_BYTES*BYTE_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
      logic [BYTE_W-1:0] lane [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && wr_be[b]) lane[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
      end

      assign rd_data[b*BYTE_W +: BYTE_W] = lane[rd_addr];
   end

endmodule

// File: rtl/nbt_read_path.sv
module nbt_read_path
   import nbt_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int NUM_BYTES = 2,
   parameter int BYTE_W    = 9
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        pipe_mode,
   input  op_e                         s1_op,
   input  logic [ADDR_W-1:0]           s1_addr,
   input  op_e                         s2_op,
   input  logic [ADDR_W-1:0]           s2_addr,
   input  logic [NUM_BYTES-1:0]        s2_be,
   input  logic [NUM_BYTES*BYTE_W-1:0] mem_q,
   input  logic [NUM_BYTES*BYTE_W-1:0] wr_data,
   output logic [NUM_BYTES*BYTE_W-1:0] rd_data,
   output logic                        rd_drive
);

   localparam int DATA_W = NUM_BYTES * BYTE_W;

   logic              hit, q_vld;
   logic [DATA_W-1:0] fwd, q_reg;

   assign hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);

   // write landing at the capture edge is merged lane by lane
   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_fwd
      assign fwd[b*BYTE_W +: BYTE_W] = (hit && s2_be[b]) ? wr_data[b*BYTE_W +: BYTE_W]
                                                         : mem_q[b*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_vld <= 1'b0;
         q_reg <= '0;
      end else begin
         q_vld <= (s1_op == OP_READ);
         q_reg <= fwd;
      end
   end

   assign rd_data  = pipe_mode ? q_reg : mem_q;
   assign rd_drive = pipe_mode ? q_vld : (s1_op == OP_READ);

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
   import nbt_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int NUM_BYTES = 2,
   parameter int BYTE_W    = 9
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        pipe_mode,
   input  logic                        interleave,
   input  logic                        ce0,
   input  logic                        ce1,
   input  logic                        ce2,
   input  logic                        adv,
   input  logic                        wr,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [NUM_BYTES-1:0]        byte_we,
   input  logic [NUM_BYTES*BYTE_W-1:0] dq_in,
   input  logic                        oe,
   input  logic                        sleep,
   output logic [NUM_BYTES*BYTE_W-1:0] dq_out,
   output logic                        dq_oe
);

   localparam int DATA_W = NUM_BYTES * BYTE_W;

   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("nbt_sram: ADDR_W must be at least 3");
   end
   if (NUM_BYTES < 1 || BYTE_W < 1) begin : g_bad_lanes
      $error("nbt_sram: NUM_BYTES and BYTE_W must be positive");
   end

   op_e                  s1_op, s2_op;
   logic [ADDR_W-1:0]    s1_addr, s2_addr, wa;
   logic [NUM_BYTES-1:0] s1_be, s2_be, wbe;
   logic                 we_now, rd_drive;
   logic [DATA_W-1:0]    mem_q, rd_data;

   nbt_burst_ctl #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) u_ctl (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .cmd_sel(ce0 && ce1 && ce2),
      .adv(adv), .wr(wr), .interleave(interleave), .addr(addr), .byte_we(byte_we),
      .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be)
   );

   // second stage for the double-late write and the bypass compare
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_op   <= OP_NONE;
         s2_addr <= '0;
         s2_be   <= '0;
      end else begin
         s2_op   <= s1_op;
         s2_addr <= s1_addr;
         s2_be   <= s1_be;
      end
   end

   always_comb begin
      if (pipe_mode) begin
         we_now = (s2_op == OP_WRITE);
         wa     = s2_addr;
         wbe    = s2_be;
      end else begin
         we_now = (s1_op == OP_WRITE);
         wa     = s1_addr;
         wbe    = s1_be;
      end
   end

   nbt_mem_array #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_mem (
      .clk(clk), .wr_en(we_now), .wr_addr(wa), .wr_be(wbe), .wr_data(dq_in),
      .rd_addr(s1_addr), .rd_data(mem_q)
   );

   nbt_read_path #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
      .s1_op(s1_op), .s1_addr(s1_addr), .s2_op(s2_op), .s2_addr(s2_addr), .s2_be(s2_be),
      .mem_q(mem_q), .wr_data(dq_in), .rd_data(rd_data), .rd_drive(rd_drive)
   );

   assign dq_out = rd_data;
   assign dq_oe  = rd_drive && oe && !sleep;

endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(
   parameter int ADDR_W    = 4,
   parameter int NUM_BYTES = 2,
   parameter int BYTE_W    = 9
) (
   input logic clk,
   input logic rst_n,
   input logic pipe_mode,
   input logic ce0,
   input logic ce1,
   input logic ce2,
   input logic adv,
   input logic wr,
   input logic oe,
   input logic sleep,
   input logic dq_oe
);

   logic all_sel;
   assign all_sel = ce0 && ce1 && ce2;

   p_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> !dq_oe);

   p_sleep_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dq_oe);

   p_flow_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_mode && all_sel && !adv && !wr && !sleep) |=> (dq_oe || !oe || sleep));

   p_pipe_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && all_sel && !adv && !wr && !sleep) |=> ##1 (dq_oe || !oe || sleep));

   p_flow_wslot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_mode && all_sel && !adv && wr && !sleep) |=> !dq_oe);

   p_pipe_wslot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && all_sel && !adv && wr && !sleep) |=> ##1 !dq_oe);

   p_flow_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_mode && !all_sel && !adv && !sleep) |=> !dq_oe);

   p_pipe_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && !all_sel && !adv && !sleep) |=> ##1 !dq_oe);

endmodule

bind nbt_sram nbt_sram_chk #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .ce0(ce0), .ce1(ce1), .ce2(ce2),
   .adv(adv), .wr(wr), .oe(oe), .sleep(sleep), .dq_oe(dq_oe)
);

// File: tb/nbt_sram_test.sv
module nbt_sram_test;

   localparam int AW = 4;
   localparam int NB = 2;
   localparam int BW = 9;
   localparam int DW = NB * BW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pipe_mode = 1'b0, interleave = 1'b0;
   logic          ce0 = 1'b0, ce1 = 1'b0, ce2 = 1'b0;
   logic          adv = 1'b0, wr = 1'b0, oe = 1'b1, sleep = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [NB-1:0] byte_we = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;

   always #10 clk = ~clk;

   nbt_sram #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(BW)) uut (
      .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .interleave(interleave),
      .ce0(ce0), .ce1(ce1), .ce2(ce2), .adv(adv), .wr(wr), .addr(addr),
      .byte_we(byte_we), .dq_in(dq_in), .oe(oe), .sleep(sleep),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   int checks = 0, errors = 0, cyc = 0;
   bit probe = 1'b0;

   logic [DW-1:0] model_mem [DEPTH];
   int            last_wr   [DEPTH];
   bit            partial   [DEPTH];

   bit            s_rd   [8];
   logic [AW-1:0] s_addr [8];
   string         s_tag  [8];
   bit            w_v    [8];
   logic [AW-1:0] w_addr [8];
   logic [NB-1:0] w_be   [8];

   bit            b_act, b_we;
   logic [AW-1:0] b_base;
   logic [1:0]    b_cnt;

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_v,
                                           input logic [DW-1:0] new_v,
                                           input logic [NB-1:0] be);
      logic [DW-1:0] r = old_v;
      for (int i = 0; i < NB; i++)
         if (be[i]) r[i*BW +: BW] = new_v[i*BW +: BW];
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
      end
   endtask

   task automatic clear_slots();
      for (int i = 0; i < 8; i++) begin
         s_rd[i] = 1'b0; s_tag[i] = "R8"; w_v[i] = 1'b0;
      end
      b_act = 1'b0;
   endtask

   task automatic check_cycle();
      int s = cyc % 8;
      bit exp_oe;
      if (probe && s_rd[s] && oe && !sleep) begin
         oe = 1'b0; #1;
         chk(dq_oe === 1'b0, "R9", "oe low async", DW'(dq_oe), '0);
         oe = 1'b1; sleep = 1'b1; #1;
         chk(dq_oe === 1'b0, "R10", "sleep async", DW'(dq_oe), '0);
         sleep = 1'b0; #1;
      end
      exp_oe = s_rd[s] && oe && !sleep;
      chk(dq_oe === exp_oe, s_tag[s], "drive", DW'(dq_oe), DW'(exp_oe));
      if (s_rd[s])
         chk(dq_out === model_mem[s_addr[s]], s_tag[s], "data", dq_out, model_mem[s_addr[s]]);
      s_rd[s] = 1'b0;
      s_tag[s] = "R8";
   endtask

   task automatic run(input logic [2:0] en, input bit w, input bit av,
                      input logic [AW-1:0] a, input logic [NB-1:0] be,
                      input bit slp, input bit oev, input string ft);
      int o, so, sw;
      bit vld = 1'b0, iswr = 1'b0, isload = 1'b0;
      logic [AW-1:0] ea = a;
      logic [DW-1:0] d;
      string tg = "R8";
      check_cycle();
      sw = cyc % 8;
      d = DW'($urandom);
      dq_in = d;
      if (w_v[sw]) begin
         model_mem[w_addr[sw]] = merge(model_mem[w_addr[sw]], d, w_be[sw]);
         last_wr[w_addr[sw]] = cyc;
         partial[w_addr[sw]] = (w_be[sw] != '1);
         w_v[sw] = 1'b0;
      end
      {ce2, ce1, ce0} = en;
      wr = w; adv = av; addr = a; byte_we = be; sleep = slp; oe = oev;
      o = cyc + (pipe_mode ? 2 : 1);
      so = o % 8;
      if (slp) tg = "R10";
      else if (!av) begin
         if (&en) begin
            b_act = 1'b1; b_we = w; b_base = a; b_cnt = 2'd0;
            vld = 1'b1; iswr = w; isload = 1'b1;
         end else b_act = 1'b0;
      end else if (b_act) begin
         b_cnt = b_cnt + 2'd1;
         ea = {b_base[AW-1:2], interleave ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
         vld = 1'b1; iswr = b_we;
         tg = interleave ? "R6" : "R5";
      end else tg = "R12";
      if (vld && iswr) begin
         w_v[so] = 1'b1; w_addr[so] = ea; w_be[so] = be; tg = "R3";
      end
      if (vld && !iswr) begin
         s_rd[so] = 1'b1; s_addr[so] = ea;
         if (ft != "") tg = ft;
         else if (isload) begin
            if (pipe_mode && w_v[(o-1)%8] && w_addr[(o-1)%8] == ea) tg = "R11";
            else if (cyc + 1 - last_wr[ea] <= 4) tg = "R3";
            else if (partial[ea]) tg = "R7";
            else tg = pipe_mode ? "R2" : "R1";
         end
      end
      s_tag[so] = tg;
      @(negedge clk);
      cyc++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) run(3'b000, 1'b0, 1'b0, '0, '0, 1'b0, 1'b1, "");
   endtask

   task automatic do_reset(input bit pm, input bit ilv);
      rst_n = 1'b0; pipe_mode = pm; interleave = ilv;
      {ce2, ce1, ce0} = 3'b000; adv = 1'b0; sleep = 1'b0; oe = 1'b1;
      for (int i = 0; i < 3; i++) begin @(negedge clk); cyc++; end
      clear_slots();
      rst_n = 1'b1;
   endtask

   task automatic random_phase(input int n);
      for (int i = 0; i < n; i++) begin
         int r = $urandom % 16;
         logic [2:0] en = 3'b111;
         bit av = (r >= 3 && r <= 6) || (r == 0 && $urandom % 2 == 1);
         bit w = (r >= 12) || (av && $urandom % 2 == 1);
         if (r == 1 || r == 2) en = 3'($urandom % 7);
         else if (av) en = 3'($urandom);
         run(en, w, av, AW'($urandom), NB'($urandom), r == 0, ($urandom % 10) != 0, "");
      end
   endtask

   initial begin
      void'($urandom(32'd5417));
      for (int i = 0; i < DEPTH; i++) begin last_wr[i] = -100; partial[i] = 1'b0; end
      clear_slots();
      do_reset(1'b0, 1'b0);
      // reset state: nothing driven (R8)
      #1 chk(dq_oe === 1'b0, "R8", "reset drive", DW'(dq_oe), '0);
      #1;
      // fill every word in flow-through mode
      for (int a = 0; a < DEPTH; a++) run(3'b111, 1'b1, 1'b0, AW'(a), '1, 1'b0, 1'b1, "");
      idle(3);
      // R1 plain reads, R7 partial write, R8 and R12 ignored cycles
      run(3'b111, 1'b0, 1'b0, 4'd9, '0, 1'b0, 1'b1, "R1");
      run(3'b111, 1'b1, 1'b0, 4'd3, 2'b10, 1'b0, 1'b1, "");
      idle(6);
      run(3'b111, 1'b0, 1'b0, 4'd3, '0, 1'b0, 1'b1, "");
      run(3'b011, 1'b0, 1'b0, 4'd3, '0, 1'b0, 1'b1, "");
      run(3'b000, 1'b0, 1'b1, 4'd3, '0, 1'b0, 1'b1, "");
      idle(2);
      // R5 linear read burst from 6: 6,7,4,5 ; R9/R10 async probes on it
      probe = 1'b1;
      run(3'b111, 1'b0, 1'b0, 4'd6, '0, 1'b0, 1'b1, "");
      for (int i = 0; i < 3; i++) run(3'b000, 1'b0, 1'b1, '0, '0, 1'b0, 1'b1, "");
      probe = 1'b0;
      idle(2);
      random_phase(1200);
      idle(4);

      // pipelined, interleaved
      do_reset(1'b1, 1'b1);
      // R6 interleaved write then read burst from 13: 13,12,15,14
      run(3'b111, 1'b1, 1'b0, 4'd13, '1, 1'b0, 1'b1, "");
      for (int i = 0; i < 3; i++) run(3'b000, 1'b0, 1'b1, '0, '1, 1'b0, 1'b1, "");
      run(3'b111, 1'b0, 1'b0, 4'd13, '0, 1'b0, 1'b1, "R6");
      probe = 1'b1;
      for (int i = 0; i < 3; i++) run(3'b000, 1'b0, 1'b1, '0, '0, 1'b0, 1'b1, "");
      probe = 1'b0;
      idle(3);
      // R4 read-write-read-write-read on one word, no gaps
      run(3'b111, 1'b0, 1'b0, 4'd2, '0, 1'b0, 1'b1, "R4");
      run(3'b111, 1'b1, 1'b0, 4'd2, '1, 1'b0, 1'b1, "");
      run(3'b111, 1'b0, 1'b0, 4'd2, '0, 1'b0, 1'b1, "R4");
      run(3'b111, 1'b1, 1'b0, 4'd2, 2'b01, 1'b0, 1'b1, "");
      run(3'b111, 1'b0, 1'b0, 4'd2, '0, 1'b0, 1'b1, "R4");
      idle(3);
      // R11 read directly behind a partial write to the same word
      run(3'b111, 1'b1, 1'b0, 4'd5, 2'b10, 1'b0, 1'b1, "");
      run(3'b111, 1'b0, 1'b0, 4'd5, '0, 1'b0, 1'b1, "");
      idle(3);
      random_phase(1200);
      idle(4);

      do_reset(1'b0, 1'b1);
      random_phase(600);
      do_reset(1'b1, 1'b0);
      random_phase(600);
      idle(4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog expired at cycle %0d (all requirements)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule